// File: doc/BRIEF.md
# Link Status Generator with Holdoff

This block makes the single link-status bit of an Ethernet PHY and can route it to one of three output pins. A 16-bit control register, reached over a simple read/write bus at one address, picks where the status comes from. It can be held low, follow the PLCA status input, follow a bit that software writes, or follow an activity detector. The activity detector watches beacon detection when the node is a follower and packet reception from another node when it is the coordinator. The PLCA engine, the beacon detector and the packet receiver are outside the block and feed it through inputs.

In the PLCA-status and activity modes a holdoff timer delays the drop of the status to false. The timer counts 1 ms ticks from an input. It reloads whenever the source is active. The status falls only when the count reaches the programmed threshold while the source stays inactive. The fixed and semaphore modes bypass the timer.

The routed pin is chosen by a code in the register. One of the pins is shared with a general-purpose function of the chip. When that pin is selected for link status, the link status overrides the shared function.

Top module: `link_status_gen`

## Requirements
- R1: After reset the register reads 0x0000, `link_o` is 0 and no pin carries link status: `pin_o` bits 0 and 2 are 0, and bit 1 follows `gpio_alt_i`.
- R2: A write with `bus_addr_i` = 0x0012 stores bits 15:9 and bit 0. A read of 0x0012 returns those bits, with bits 8:1 reading 0. A write to any other address changes nothing, and a read of any other address returns 0.
- R3: With mode field bits 12:11 = 00 (fixed), `link_o` is 0 one clock later, whatever the other inputs are.
- R4: With mode 01 (PLCA status) and `plca_en_i` high, `link_o` goes to 1 on the clock after `plca_status_i` is seen high.
- R5: With mode 10 (semaphore), `link_o` takes the value of register bit 0 on the clock after the register holds it, so a write shows on `link_o` two edges after the write is presented.
- R6: With mode 11 (activity) and `plca_en_i` high, the source is `beacon_det_i` when `is_coord_i` is 0 and `pkt_rx_i` when `is_coord_i` is 1. The input not selected by the role has no effect.
- R7: In modes 01 and 11, `plca_en_i` low drives `link_o` to 0 on the next clock, with no holdoff.
- R8: In modes 01 and 11, once the source is inactive, `link_o` stays 1 until the Nth `tick_1ms_i` pulse and drops on that pulse. N is 15, 100, 500 or 1000 for timer bits 10:9 = 00, 01, 10 or 11. A source pulse before that restarts the count.
- R9: Pin-select bits 15:13 = 001, 010 and 011 put `link_o` on `pin_o` bit 0, bit 1 and bit 2 respectively. The unselected pins 0 and 2 are driven 0.
- R10: Pin-select codes 000 and 100 to 111 put link status on no pin. Pin 1 carries `gpio_alt_i` unless code 010 is selected, in which case link status overrides `gpio_alt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 16 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| tick_1ms_i | input | 1 | One-cycle pulse every millisecond |
| plca_en_i | input | 1 | PLCA enabled |
| plca_status_i | input | 1 | PLCA status from the PLCA engine |
| is_coord_i | input | 1 | Node is the PLCA coordinator |
| beacon_det_i | input | 1 | Beacons currently detected |
| pkt_rx_i | input | 1 | Packet received from another node |
| gpio_alt_i | input | 1 | Shared general-purpose function for pin 1 |
| link_o | output | 1 | Link status |
| pin_o | output | 3 | Routed pins |

## Verification
The hardest case to reach is the exact tick on which the holdoff ends, especially the 1000-tick setting and the restart of the count part-way through. The stimulus drives `tick_1ms_i` as single-cycle pulses, one per call, instead of at a real 1 ms period. It can then step to one tick short of each threshold, check that the status still holds, and issue the final tick. The role-dependent source in activity mode is reached by changing `is_coord_i` while holding the other role's input active, so that an input with no effect would show up as a missed drop.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED = 2'b00,
    MODE_PLCA  = 2'b01,
    MODE_SEM   = 2'b10,
    MODE_ACT   = 2'b11
  } ls_mode_e;

  typedef struct packed {
    logic [2:0] pin_sel;
    ls_mode_e   mode;
    logic [1:0] hold_sel;
    logic       sem;
  } lsg_ctrl_t;
endpackage

// File: rtl/lsg_ctrl_reg.sv
module lsg_ctrl_reg
  import lsg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0012
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output lsg_ctrl_t         ctrl_o
);
  localparam int unsigned GAP_W = DATA_W - 8;

  lsg_ctrl_t ctrl_q;
  logic      hit;

  assign hit = (bus_addr_i == REG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (bus_we_i && hit) begin
      ctrl_q.pin_sel  <= bus_wdata_i[15:13];
      ctrl_q.mode     <= ls_mode_e'(bus_wdata_i[12:11]);
      ctrl_q.hold_sel <= bus_wdata_i[10:9];
      ctrl_q.sem      <= bus_wdata_i[0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit) begin
      bus_rdata_o = {ctrl_q.pin_sel, ctrl_q.mode, ctrl_q.hold_sel, {GAP_W{1'b0}}, ctrl_q.sem};
    end
  end

  assign ctrl_o = ctrl_q;

  // R2: accepted write lands in the register
  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && hit) |=> (ctrl_q.sem == $past(bus_wdata_i[0]) &&
                           ctrl_q.pin_sel == $past(bus_wdata_i[15:13])));
  // R2: foreign address leaves register alone
  p_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(bus_we_i && hit)) |=> $stable(ctrl_q));
endmodule

// File: rtl/lsg_src_sel.sv
module lsg_src_sel
  import lsg_pkg::*;
(
  input  ls_mode_e mode_i,
  input  logic     plca_status_i,
  input  logic     is_coord_i,
  input  logic     beacon_det_i,
  input  logic     pkt_rx_i,
  output logic     timed_o,
  output logic     src_act_o
);
  logic act_src;

  assign act_src = is_coord_i ? pkt_rx_i : beacon_det_i;

  always_comb begin
    timed_o   = 1'b0;
    src_act_o = 1'b0;
    unique case (mode_i)
      MODE_PLCA: begin timed_o = 1'b1; src_act_o = plca_status_i; end
      MODE_ACT:  begin timed_o = 1'b1; src_act_o = act_src;       end
      default:   ;
    endcase
  end
endmodule

// File: rtl/lsg_holdoff.sv
module lsg_holdoff
  import lsg_pkg::*;
#(
  parameter int unsigned HOLD_MS0 = 15,
  parameter int unsigned HOLD_MS1 = 100,
  parameter int unsigned HOLD_MS2 = 500,
  parameter int unsigned HOLD_MS3 = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ls_mode_e   mode_i,
  input  logic       sem_i,
  input  logic [1:0] hold_sel_i,
  input  logic       timed_i,
  input  logic       src_act_i,
  input  logic       plca_en_i,
  input  logic       tick_i,
  output logic       link_o
);
  // HOLD_MS3 is the largest setting
  localparam int unsigned CNT_W = $clog2(HOLD_MS3 + 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, thr;
  logic             link_q;

  always_comb begin
    unique case (hold_sel_i)
      2'd0:    thr = CNT_W'(HOLD_MS0);
      2'd1:    thr = CNT_W'(HOLD_MS1);
      2'd2:    thr = CNT_W'(HOLD_MS2);
      default: thr = CNT_W'(HOLD_MS3);
    endcase
  end

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!timed_i) begin
      cnt_q  <= '0;
      link_q <= (mode_i == MODE_SEM) ? sem_i : 1'b0;
    end else if (!plca_en_i) begin
      cnt_q  <= '0;
      link_q <= 1'b0;
    end else if (src_act_i) begin
      cnt_q  <= '0;
      link_q <= 1'b1;
    end else if (link_q && tick_i) begin
      if (cnt_nxt >= thr) begin
        cnt_q  <= '0;
        link_q <= 1'b0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign link_o = link_q;

  p_fixed_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FIXED) |=> !link_o);
  p_sem_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SEM) |=> (link_o == $past(sem_i)));
  p_src_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed_i && plca_en_i && src_act_i) |=> link_o);
  p_plca_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed_i && !plca_en_i) |=> !link_o);
  // R8: in a timed mode with PLCA on, a drop only happens on a tick
  p_drop_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed_i && plca_en_i && link_o && !src_act_i && !tick_i) |=> link_o);
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < thr || !link_o || !timed_i);
endmodule

// File: rtl/lsg_pin_demux.sv
module lsg_pin_demux #(
  parameter int unsigned NUM_PINS = 3,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned ALT_IDX  = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    pin_sel_i,
  input  logic                link_i,
  input  logic                gpio_alt_i,
  output logic [NUM_PINS-1:0] pin_o
);
  logic [NUM_PINS-1:0] hit;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // code 0 is off, code i+1 drives pin i
    assign hit[i] = (pin_sel_i == SEL_W'(i + 1));
    if (i == ALT_IDX) begin : g_shared
      assign pin_o[i] = hit[i] ? link_i : gpio_alt_i;
    end else begin : g_plain
      assign pin_o[i] = hit[i] & link_i;
    end
  end

  p_one_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  p_off_codes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_sel_i == '0 || pin_sel_i > SEL_W'(NUM_PINS)) |-> (hit == '0));
endmodule

// File: rtl/link_status_gen.sv
module link_status_gen
  import lsg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0012,
  parameter int unsigned NUM_PINS = 3,
  parameter int unsigned HOLD_MS0 = 15,
  parameter int unsigned HOLD_MS1 = 100,
  parameter int unsigned HOLD_MS2 = 500,
  parameter int unsigned HOLD_MS3 = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [15:0]         bus_wdata_i,
  output logic [15:0]         bus_rdata_o,
  input  logic                tick_1ms_i,
  input  logic                plca_en_i,
  input  logic                plca_status_i,
  input  logic                is_coord_i,
  input  logic                beacon_det_i,
  input  logic                pkt_rx_i,
  input  logic                gpio_alt_i,
  output logic                link_o,
  output logic [NUM_PINS-1:0] pin_o
);
  lsg_ctrl_t ctrl;
  logic      timed, src_act, link;

  lsg_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(16), .REG_ADDR(REG_ADDR)) u_reg (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .ctrl_o(ctrl)
  );

  lsg_src_sel u_src (
    .mode_i(ctrl.mode), .plca_status_i, .is_coord_i, .beacon_det_i, .pkt_rx_i,
    .timed_o(timed), .src_act_o(src_act)
  );

  lsg_holdoff #(
    .HOLD_MS0(HOLD_MS0), .HOLD_MS1(HOLD_MS1), .HOLD_MS2(HOLD_MS2), .HOLD_MS3(HOLD_MS3)
  ) u_hold (
    .clk_i, .rst_ni, .mode_i(ctrl.mode), .sem_i(ctrl.sem), .hold_sel_i(ctrl.hold_sel),
    .timed_i(timed), .src_act_i(src_act), .plca_en_i, .tick_i(tick_1ms_i),
    .link_o(link)
  );

  lsg_pin_demux #(.NUM_PINS(NUM_PINS), .SEL_W(3), .ALT_IDX(1)) u_pins (
    .clk_i, .rst_ni, .pin_sel_i(ctrl.pin_sel), .link_i(link), .gpio_alt_i,
    .pin_o
  );

  assign link_o = link;
endmodule

// File: tb/link_status_gen_tb.sv
module link_status_gen_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = 16'h0012;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tick = 1'b0, plca_en = 1'b0, plca_status = 1'b0;
  logic        is_coord = 1'b0, beacon = 1'b0, pkt_rx = 1'b0, gpio_alt = 1'b0;
  logic        link;
  logic [2:0]  pins;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 link, 1 pins, 2 rdata
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  link_status_gen u_dut (
    .clk_i(clk), .rst_ni, .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .tick_1ms_i(tick),
    .plca_en_i(plca_en), .plca_status_i(plca_status), .is_coord_i(is_coord),
    .beacon_det_i(beacon), .pkt_rx_i(pkt_rx), .gpio_alt_i(gpio_alt),
    .link_o(link), .pin_o(pins)
  );

  // monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = {15'b0, link};
        1:       act = {13'b0, pins};
        default: act = bus_rdata;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_val(int kind, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [15:0] addr, logic [15:0] data);
    bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
    step(1);
    bus_we = 1'b0; bus_addr = 16'h0012;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step(1);
      tick = 1'b0;
    end
  endtask

  // source already low and sampled; check hold to N-1 and drop at N
  task automatic hold_check(int n, string tag);
    ticks(n - 1);
    expect_val(0, 16'd1, {tag, " held before last tick"});
    ticks(1);
    expect_val(0, 16'd0, {tag, " dropped on last tick"});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(2);
    // R1 reset state
    expect_val(2, 16'h0000, "R1 reset rdata");
    expect_val(0, 16'd0, "R1 reset link");
    expect_val(1, 16'd0, "R1 reset pins");
    rst_ni = 1'b1;
    step(1);

    // R2 register access
    wr(16'h0012, 16'hFFFF);
    expect_val(2, 16'hFE01, "R2 readback with bits 8:1 zero");
    wr(16'h0013, 16'h0000);
    expect_val(2, 16'hFE01, "R2 foreign write ignored");
    bus_addr = 16'h0013;
    expect_val(2, 16'h0000, "R2 foreign read zero");
    bus_addr = 16'h0012;

    // R3 fixed mode ignores sources
    plca_en = 1'b1; plca_status = 1'b1; beacon = 1'b1;
    wr(16'h2000, 16'h0000);
    wr(16'h0012, 16'h2000);
    step(1);
    expect_val(0, 16'd0, "R3 fixed mode low");
    expect_val(2, 16'h2000, "R3 register value");

    // R4 PLCA status, timer 15
    wr(16'h0012, 16'h2800);
    step(1);
    expect_val(0, 16'd1, "R4 follows plca status");
    expect_val(1, 16'h0001, "R9 pin0 carries link");
    plca_status = 1'b0;
    step(1);
    hold_check(15, "R8 code00 15 ticks");

    // R8 restart of count
    plca_status = 1'b1; step(1);
    plca_status = 1'b0; step(1);
    ticks(10);
    plca_status = 1'b1; step(1);
    plca_status = 1'b0; step(1);
    hold_check(15, "R8 restart then 15 ticks");

    // R7 plca disabled forces low
    plca_status = 1'b1; step(1);
    expect_val(0, 16'd1, "R7 link up before disable");
    plca_en = 1'b0;
    step(1);
    expect_val(0, 16'd0, "R7 disable drops at once");
    plca_en = 1'b1; plca_status = 1'b0; step(1);

    // R8 other thresholds
    wr(16'h0012, 16'h2A00);
    plca_status = 1'b1; step(1); plca_status = 1'b0; step(1);
    hold_check(100, "R8 code01 100 ticks");
    wr(16'h0012, 16'h2C00);
    plca_status = 1'b1; step(1); plca_status = 1'b0; step(1);
    hold_check(500, "R8 code10 500 ticks");
    wr(16'h0012, 16'h2E00);
    plca_status = 1'b1; step(1); plca_status = 1'b0; step(1);
    hold_check(1000, "R8 code11 1000 ticks");

    // R6 activity, follower
    wr(16'h0012, 16'h3800);
    is_coord = 1'b0; beacon = 1'b1; pkt_rx = 1'b0;
    step(1);
    expect_val(0, 16'd1, "R6 follower beacon raises link");
    beacon = 1'b0; pkt_rx = 1'b1;
    step(1);
    hold_check(15, "R6 follower ignores pkt_rx");
    // R6 activity, coordinator
    is_coord = 1'b1; beacon = 1'b1; pkt_rx = 1'b0;
    step(1);
    expect_val(0, 16'd0, "R6 coordinator ignores beacon");
    pkt_rx = 1'b1; step(1); pkt_rx = 1'b0;
    expect_val(0, 16'd1, "R6 coordinator packet raises link");
    step(1);
    hold_check(15, "R6 coordinator holdoff");
    beacon = 1'b0;

    // R5 semaphore, pin 010
    wr(16'h0012, 16'h2000);
    step(1);
    gpio_alt = 1'b0;
    wr(16'h0012, 16'h5001);
    expect_val(0, 16'd0, "R5 not yet on write edge");
    step(1);
    expect_val(0, 16'd1, "R5 semaphore set");
    expect_val(1, 16'h0002, "R9 pin1 carries link");
    gpio_alt = 1'b1;
    wr(16'h0012, 16'h5000);
    step(1);
    expect_val(0, 16'd0, "R5 semaphore cleared");
    expect_val(1, 16'h0000, "R10 link overrides gpio_alt on pin1");

    // R9 / R10 pin routing with link high, gpio_alt high
    wr(16'h0012, 16'h3001); step(1);
    expect_val(1, 16'h0003, "R9 code001 pin0 plus alt");
    wr(16'h0012, 16'h7001); step(1);
    expect_val(1, 16'h0006, "R9 code011 pin2 plus alt");
    wr(16'h0012, 16'h1001); step(1);
    expect_val(1, 16'h0002, "R10 code000 no pin");
    wr(16'h0012, 16'h9001); step(1);
    expect_val(1, 16'h0002, "R10 code100 reserved");
    wr(16'h0012, 16'hF001); step(1);
    expect_val(1, 16'h0002, "R10 code111 reserved");
    expect_val(0, 16'd1, "R10 link still high");

    step(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule